// File: doc/BRIEF.md
# Full-Map Directory Home Controller

This block is the home-node coherence controller for a small write-invalidate multiprocessor with non-uniform memory. For every memory block it owns, it keeps one directory word: a dirty flag plus one presence bit for each cache in the system. Caches send it read misses, write misses, upgrade requests for copies they already hold clean, and eviction notices, each carrying the requesting cache id and the block index. The controller looks up the word, issues the coherence commands the request needs (invalidations, a fetch from the current owner, a memory writeback, and finally data or a write grant to the requester), then updates the word.

Commands leave on a single valid/ready channel. Invalidation acknowledgements and the owner's fetch response return on a one-bit acknowledge strobe that the controller counts. The data payload and the memory array are outside the block; a writeback to memory is a command addressed to the home cache id. Only one transaction is open at a time. While it waits for acknowledges, another request to the same block is accepted and refused with a negative acknowledge so its sender retries later; requests to other blocks are held off with ready low.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every directory word is zero (bit 0 is the dirty flag, bit c+1 is the presence bit of cache c), no command is valid and a request is accepted. A read miss (request op 0) to a word that is all zero sends data (command op 0) to the requester and leaves the word clean with only the requester present.
- R2: A read miss to a clean word with sharers sends data to the requester with no invalidations and adds the requester's presence bit.
- R3: A read miss to a dirty word fetches from the owner, waits for one acknowledge, sends a memory writeback (op 5, destination the home id), then data to the requester; the word becomes clean with owner and requester present.
- R4: The fetch command is op 3 when the owner is the home node's own cache (id HOME_ID) and op 4 when the owner is a remote cache.
- R5: A write miss (request op 1) to an all-zero word sends data and leaves the word dirty with only the requester present.
- R6: A write miss to a clean word sends one invalidate (op 2) to each present cache other than the requester, in ascending id order, and sends data only after as many acknowledges as invalidates have arrived; the word becomes dirty with only the requester present.
- R7: A write miss to a dirty word fetches from the owner, writes memory back, then sends data; the word stays dirty with only the requester present.
- R8: An upgrade (request op 2) from a cache whose presence bit is set in a clean word follows the R6 path but ends with a grant (op 1) instead of data; an upgrade from any other cache behaves as a write miss.
- R9: An eviction (request op 3) by the owner of a dirty word sends a memory writeback and zeroes the word; any other eviction issues no command and clears only the evicting cache's presence bit.
- R10: While a transaction waits for acknowledges, a request to its block is accepted and answered with a negative acknowledge (op 6) to the sender, leaving the word untouched; a request to any other block is not accepted.
- R11: A valid command holds its op, destination and block until it is taken; each transaction's commands appear in the order fetch or invalidates, writeback, response.
- R12: A dirty directory word never has more than one presence bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken this cycle when high with valid |
| req_op_i | input | 2 | 0 read miss, 1 write miss, 2 upgrade, 3 eviction |
| req_src_i | input | $clog2(N_CACHES) | Requesting cache id |
| req_blk_i | input | $clog2(N_BLOCKS) | Block index |
| cmd_valid_o | output | 1 | Command present |
| cmd_ready_i | input | 1 | Command taken this cycle when high with valid |
| cmd_op_o | output | 3 | 0 data, 1 grant, 2 invalidate, 3 local fetch, 4 remote fetch, 5 writeback, 6 negative acknowledge |
| cmd_dst_o | output | $clog2(N_CACHES) | Destination cache id (home id for writeback) |
| cmd_blk_o | output | $clog2(N_BLOCKS) | Block index of the command |
| ack_valid_i | input | 1 | One invalidation acknowledge or fetch response |

## Verification
The bench drives every request kind against a reference model of the directory words with random backpressure on the command channel, so a design that let a command change while stalled, or reordered invalidates, writeback and response, shows up as a miscompare. Acknowledges are delayed long enough that a controller sending data before its acknowledge count drained, or counting the requester among those to invalidate, emits the response early or an extra invalidate. A refused request is issued during that wait; a design that added the refused sender to the word would later pick it as the fetch owner, and one that accepted a different block would raise ready when it must stay low. A clean eviction is followed by a write miss whose invalidate list proves the evicting cache's bit alone was cleared, and fetches to the home cache and to a remote one check the two fetch encodings.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    REQ_RD    = 2'd0,
    REQ_WR    = 2'd1,
    REQ_UPG   = 2'd2,
    REQ_EVICT = 2'd3
  } req_op_e;

  typedef enum logic [2:0] {
    CMD_DATA      = 3'd0,
    CMD_GRANT     = 3'd1,
    CMD_INVAL     = 3'd2,
    CMD_FETCH_LOC = 3'd3,
    CMD_FETCH_FWD = 3'd4,
    CMD_WBACK     = 3'd5,
    CMD_NACK      = 3'd6
  } cmd_op_e;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DATA  = 2'd1,
    RSP_GRANT = 2'd2
  } rsp_e;
endpackage

// File: rtl/dir_prio_enc.sv
module dir_prio_enc #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec_i[k]) idx_o = IW'(k);
    end
  end
endmodule

// File: rtl/dir_entry_ram.sv
module dir_entry_ram #(
  parameter int N_BLOCKS = 8,
  parameter int EW       = 5,
  localparam int BW      = $clog2(N_BLOCKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] rd_idx_i,
  output logic [EW-1:0] rd_ent_o,
  input  logic          we_i,
  input  logic [BW-1:0] wr_idx_i,
  input  logic [EW-1:0] wr_ent_i
);
  logic [EW-1:0] mem_q [N_BLOCKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < N_BLOCKS; b++) mem_q[b] <= '0;
    end else if (we_i) begin
      mem_q[wr_idx_i] <= wr_ent_i;
    end
  end

  assign rd_ent_o = mem_q[rd_idx_i];
endmodule

// File: rtl/dir_plan.sv
module dir_plan
  import dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int HOME_ID  = 0,
  localparam int IDW     = $clog2(N_CACHES),
  localparam int CW      = $clog2(N_CACHES + 1)
) (
  input  logic [N_CACHES:0]   ent_i,
  input  req_op_e             op_i,
  input  logic [IDW-1:0]      src_i,
  output logic [N_CACHES-1:0] inv_o,
  output logic                fetch_o,
  output cmd_op_e             fetch_op_o,
  output logic [IDW-1:0]      owner_o,
  output logic                wb_o,
  output rsp_e                rsp_o,
  output logic [N_CACHES:0]   new_ent_o,
  output logic [CW-1:0]       cnt_o
);
  logic [N_CACHES-1:0] pres, me;
  logic                dirty;

  assign pres  = ent_i[N_CACHES:1];
  assign dirty = ent_i[0];

  dir_prio_enc #(.W(N_CACHES)) u_owner (.vec_i(pres), .idx_o(owner_o));

  assign fetch_op_o = (owner_o == IDW'(HOME_ID)) ? CMD_FETCH_LOC : CMD_FETCH_FWD;

  always_comb begin
    me = '0;
    me[src_i] = 1'b1;
    inv_o     = '0;
    fetch_o   = 1'b0;
    wb_o      = 1'b0;
    rsp_o     = RSP_NONE;
    new_ent_o = ent_i;
    case (op_i)
      REQ_RD: begin
        rsp_o     = RSP_DATA;
        new_ent_o = {pres | me, 1'b0};
        if (dirty) begin
          fetch_o = 1'b1;
          wb_o    = 1'b1;
        end
      end
      REQ_WR, REQ_UPG: begin
        rsp_o     = RSP_DATA;
        new_ent_o = {me, 1'b1};
        if (dirty) begin
          fetch_o = 1'b1;
          wb_o    = 1'b1;
        end else begin
          inv_o = pres & ~me;
          if (op_i == REQ_UPG && pres[src_i]) rsp_o = RSP_GRANT;
        end
      end
      default: begin
        if (dirty && pres[src_i]) begin
          wb_o      = 1'b1;
          new_ent_o = '0;
        end else begin
          new_ent_o = {pres & ~me, dirty};
        end
      end
    endcase
  end

  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < N_CACHES; k++) cnt_o = cnt_o + CW'(inv_o[k]);
    if (fetch_o) cnt_o = CW'(1);
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int N_BLOCKS = 8,
  parameter int HOME_ID  = 0,
  localparam int IDW     = $clog2(N_CACHES),
  localparam int BW      = $clog2(N_BLOCKS),
  localparam int CW      = $clog2(N_CACHES + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic [1:0]     req_op_i,
  input  logic [IDW-1:0] req_src_i,
  input  logic [BW-1:0]  req_blk_i,
  output logic           cmd_valid_o,
  input  logic           cmd_ready_i,
  output logic [2:0]     cmd_op_o,
  output logic [IDW-1:0] cmd_dst_o,
  output logic [BW-1:0]  cmd_blk_o,
  input  logic           ack_valid_i
);
  typedef enum logic [2:0] {
    S_IDLE, S_INV, S_FETCH, S_WAIT, S_PICK, S_WB, S_RESP
  } st_e;

  st_e                 st_q;
  logic [IDW-1:0]      src_q, owner_q, nack_dst_q, inv_idx;
  logic [BW-1:0]       blk_q;
  logic [N_CACHES-1:0] inv_q, inv_clr;
  logic                wb_q, nack_q;
  cmd_op_e             fop_q;
  rsp_e                rsp_q;
  logic [N_CACHES:0]   new_q, rd_ent;
  logic [CW-1:0]       cnt_q;

  logic [N_CACHES-1:0] p_inv;
  logic                p_fetch, p_wb;
  cmd_op_e             p_fop;
  logic [IDW-1:0]      p_owner;
  rsp_e                p_rsp;
  logic [N_CACHES:0]   p_new;
  logic [CW-1:0]       p_cnt;

  logic cmd_fire, acc_nack, commit, busy;

  dir_entry_ram #(.N_BLOCKS(N_BLOCKS), .EW(N_CACHES + 1)) u_ram (
    .clk_i, .rst_ni,
    .rd_idx_i(req_blk_i), .rd_ent_o(rd_ent),
    .we_i(commit), .wr_idx_i(blk_q), .wr_ent_i(new_q)
  );

  dir_plan #(.N_CACHES(N_CACHES), .HOME_ID(HOME_ID)) u_plan (
    .ent_i(rd_ent), .op_i(req_op_e'(req_op_i)), .src_i(req_src_i),
    .inv_o(p_inv), .fetch_o(p_fetch), .fetch_op_o(p_fop), .owner_o(p_owner),
    .wb_o(p_wb), .rsp_o(p_rsp), .new_ent_o(p_new), .cnt_o(p_cnt)
  );

  dir_prio_enc #(.W(N_CACHES)) u_inv_sel (.vec_i(inv_q), .idx_o(inv_idx));

  always_comb begin
    inv_clr = '0;
    inv_clr[inv_idx] = 1'b1;
  end

  assign busy        = (st_q != S_IDLE);
  assign req_ready_o = (st_q == S_IDLE) ||
                       (st_q == S_WAIT && !nack_q && req_blk_i == blk_q);
  assign cmd_fire    = cmd_valid_o && cmd_ready_i;
  assign acc_nack    = req_valid_i && req_ready_o && (st_q == S_WAIT);
  assign commit      = (st_q == S_PICK) && !wb_q && (rsp_q == RSP_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      src_q      <= '0;
      blk_q      <= '0;
      owner_q    <= '0;
      nack_dst_q <= '0;
      inv_q      <= '0;
      wb_q       <= 1'b0;
      nack_q     <= 1'b0;
      fop_q      <= CMD_FETCH_LOC;
      rsp_q      <= RSP_NONE;
      new_q      <= '0;
      cnt_q      <= '0;
    end else begin
      if (busy && ack_valid_i && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      case (st_q)
        S_IDLE: if (req_valid_i) begin
          src_q   <= req_src_i;
          blk_q   <= req_blk_i;
          inv_q   <= p_inv;
          owner_q <= p_owner;
          fop_q   <= p_fop;
          wb_q    <= p_wb;
          rsp_q   <= p_rsp;
          new_q   <= p_new;
          cnt_q   <= p_cnt;
          st_q    <= (|p_inv) ? S_INV : (p_fetch ? S_FETCH : S_PICK);
        end
        S_INV: if (cmd_fire) begin
          inv_q <= inv_q & ~inv_clr;
          if ((inv_q & ~inv_clr) == '0) st_q <= S_WAIT;
        end
        S_FETCH: if (cmd_fire) st_q <= S_WAIT;
        S_WAIT: begin
          if (acc_nack) begin
            nack_q     <= 1'b1;
            nack_dst_q <= req_src_i;
          end else if (nack_q && cmd_ready_i) begin
            nack_q <= 1'b0;
          end
          if (cnt_q == '0 && !nack_q && !acc_nack) st_q <= S_PICK;
        end
        S_PICK: begin
          if (wb_q)                  st_q <= S_WB;
          else if (rsp_q != RSP_NONE) st_q <= S_RESP;
          else                        st_q <= S_IDLE;
        end
        S_WB: if (cmd_fire) begin
          wb_q <= 1'b0;
          st_q <= S_PICK;
        end
        S_RESP: if (cmd_fire) begin
          rsp_q <= RSP_NONE;
          st_q  <= S_PICK;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_op_o    = CMD_DATA;
    cmd_dst_o   = src_q;
    cmd_blk_o   = blk_q;
    case (st_q)
      S_INV:   begin cmd_valid_o = 1'b1; cmd_op_o = CMD_INVAL; cmd_dst_o = inv_idx; end
      S_FETCH: begin cmd_valid_o = 1'b1; cmd_op_o = fop_q;     cmd_dst_o = owner_q; end
      S_WB:    begin cmd_valid_o = 1'b1; cmd_op_o = CMD_WBACK; cmd_dst_o = IDW'(HOME_ID); end
      S_RESP:  begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = (rsp_q == RSP_GRANT) ? CMD_GRANT : CMD_DATA;
      end
      S_WAIT:  begin cmd_valid_o = nack_q; cmd_op_o = CMD_NACK; cmd_dst_o = nack_dst_q; end
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk
  import dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int N_BLOCKS = 8,
  localparam int IDW     = $clog2(N_CACHES),
  localparam int BW      = $clog2(N_BLOCKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [BW-1:0]     req_blk_i,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [2:0]        cmd_op_o,
  input logic [IDW-1:0]    cmd_dst_o,
  input logic [BW-1:0]     cmd_blk_o,
  input logic              busy,
  input logic [IDW-1:0]    src_q,
  input logic              commit,
  input logic [N_CACHES:0] new_q
);
  a_r11_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) &&
                                    $stable(cmd_dst_o) && $stable(cmd_blk_o));

  a_r10_busy_same_blk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && busy |-> req_blk_i == cmd_blk_o);

  a_r10_nack_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && busy |=> cmd_valid_o && cmd_op_o == 3'(CMD_NACK));

  a_r12_dirty_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && new_q[0] |-> $countones(new_q[N_CACHES:1]) == 1);

  a_r6_inval_skip_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == 3'(CMD_INVAL) |-> cmd_dst_o != src_q);
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.N_CACHES(N_CACHES), .N_BLOCKS(N_BLOCKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_blk_i(req_blk_i), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
  .cmd_op_o(cmd_op_o), .cmd_dst_o(cmd_dst_o), .cmd_blk_o(cmd_blk_o), .busy(busy),
  .src_q(src_q), .commit(commit), .new_q(new_q)
);

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;
  import dir_pkg::*;
  localparam int N = 4;
  localparam int NB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0, req_src = '0;
  logic [2:0] req_blk = '0;
  logic       cmd_valid, cmd_ready = 1'b1;
  logic [2:0] cmd_op, cmd_blk;
  logic [1:0] cmd_dst;
  logic       ack_v = 1'b0;

  always #4 clk = ~clk;

  dir_home_ctrl #(.N_CACHES(N), .N_BLOCKS(NB), .HOME_ID(0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_src_i(req_src), .req_blk_i(req_blk),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
    .cmd_dst_o(cmd_dst), .cmd_blk_o(cmd_blk), .ack_valid_i(ack_v)
  );

  typedef struct {
    logic [2:0] op;
    logic [1:0] dst;
    logic [2:0] blk;
    int         tag;
  } exp_t;

  exp_t       q[$];
  int         n_chk = 0, n_bad = 0, pend_ack = 0, ack_dly = 1;
  logic [N:0] ref_dir [NB];
  logic       hold_prev = 1'b0;
  logic [2:0] p_op, p_blk;
  logic [1:0] p_dst;

  function automatic void push(cmd_op_e op, int dst, int blk, int tag);
    exp_t e;
    e.op = op; e.dst = 2'(dst); e.blk = 3'(blk); e.tag = tag;
    q.push_back(e);
  endfunction

  function automatic void chk(bit ok, string rq, int act, int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp_v);
    end
  endfunction

  // backpressure on the command channel
  initial forever begin
    @(posedge clk); #1;
    cmd_ready = ($urandom_range(3) != 0);
  end

  // ack responder: one acknowledge per invalidate or fetch seen
  initial forever begin
    @(posedge clk);
    if (pend_ack > 0) begin
      repeat (ack_dly) @(posedge clk);
      #1 ack_v = 1'b1;
      pend_ack--;
      @(posedge clk);
      #1 ack_v = 1'b0;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev) begin
        n_chk++;
        if (!(cmd_valid && cmd_op == p_op && cmd_dst == p_dst && cmd_blk == p_blk)) begin
          n_bad++;
          $display("FAIL R11 stalled cmd changed actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                   cmd_op, cmd_dst, cmd_blk, p_op, p_dst, p_blk);
        end
      end
      hold_prev = cmd_valid && !cmd_ready;
      p_op = cmd_op; p_dst = cmd_dst; p_blk = cmd_blk;
      if (cmd_valid && cmd_ready) begin
        if (cmd_op == 3'(CMD_INVAL) || cmd_op == 3'(CMD_FETCH_LOC) || cmd_op == 3'(CMD_FETCH_FWD))
          pend_ack++;
        n_chk++;
        if (q.size() == 0) begin
          n_bad++;
          $display("FAIL R11 unexpected cmd actual=%0d/%0d/%0d expected=none",
                   cmd_op, cmd_dst, cmd_blk);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (!(cmd_op == e.op && cmd_dst == e.dst && cmd_blk == e.blk)) begin
            n_bad++;
            $display("FAIL R%0d op/dst/blk actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                     e.tag, cmd_op, cmd_dst, cmd_blk, e.op, e.dst, e.blk);
          end
        end
      end
    end
  end

  task automatic issue(req_op_e op, int src, int blk);
    @(posedge clk); #1;
    req_valid = 1'b1; req_op = op; req_src = 2'(src); req_blk = 3'(blk);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  // reference model: expected commands from the requirements
  task automatic xact(req_op_e op, int src, int blk, int tag);
    logic [N:0]   e;
    logic [N-1:0] pres, me;
    int           owner;
    e = ref_dir[blk];
    pres = e[N:1];
    me = '0; me[src] = 1'b1;
    owner = 0;
    for (int k = N - 1; k >= 0; k--) if (pres[k]) owner = k;
    case (op)
      REQ_RD: begin
        if (e[0]) begin
          push(owner == 0 ? CMD_FETCH_LOC : CMD_FETCH_FWD, owner, blk, tag);
          push(CMD_WBACK, 0, blk, tag);
        end
        push(CMD_DATA, src, blk, tag);
        ref_dir[blk] = {pres | me, 1'b0};
      end
      REQ_WR, REQ_UPG: begin
        if (e[0]) begin
          push(owner == 0 ? CMD_FETCH_LOC : CMD_FETCH_FWD, owner, blk, tag);
          push(CMD_WBACK, 0, blk, tag);
          push(CMD_DATA, src, blk, tag);
        end else begin
          for (int k = 0; k < N; k++) if (pres[k] && k != src) push(CMD_INVAL, k, blk, tag);
          push((op == REQ_UPG && pres[src]) ? CMD_GRANT : CMD_DATA, src, blk, tag);
        end
        ref_dir[blk] = {me, 1'b1};
      end
      default: begin
        if (e[0] && pres[src]) begin
          push(CMD_WBACK, 0, blk, tag);
          ref_dir[blk] = '0;
        end else begin
          ref_dir[blk] = {pres & ~me, e[0]};
        end
      end
    endcase
    issue(op, src, blk);
    drain();
    // R12: dirty word keeps a single presence bit
    chk(!ref_dir[blk][0] || $countones(ref_dir[blk][N:1]) == 1, "R12",
        $countones(ref_dir[blk][N:1]), 1);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) ref_dir[b] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(cmd_valid == 1'b0, "R1 no cmd after reset", cmd_valid, 0);

    xact(REQ_RD, 1, 0, 1);     // R1 uncached read
    xact(REQ_RD, 2, 0, 2);     // R2 shared read
    xact(REQ_WR, 3, 0, 6);     // R6 invalidate sharers
    xact(REQ_RD, 2, 0, 3);     // R3 dirty read, R4 remote fetch
    xact(REQ_UPG, 2, 0, 8);    // R8 upgrade by holder
    xact(REQ_WR, 1, 0, 7);     // R7 dirty write miss
    xact(REQ_EVICT, 1, 0, 9);  // R9 dirty eviction
    xact(REQ_WR, 0, 1, 5);     // R5 uncached write miss
    xact(REQ_RD, 3, 1, 4);     // R4 local fetch from home cache
    xact(REQ_EVICT, 3, 1, 9);  // R9 clean eviction: no command
    xact(REQ_WR, 2, 1, 9);     // R9 only cache 0 invalidated
    xact(REQ_UPG, 1, 1, 8);    // R8 upgrade on dirty acts as write miss
    xact(REQ_RD, 0, 2, 1);
    xact(REQ_UPG, 3, 2, 8);    // R8 upgrade by non-holder gets data

    // R10 busy block
    xact(REQ_RD, 1, 3, 2);
    xact(REQ_RD, 2, 3, 2);
    ack_dly = 20;
    push(CMD_INVAL, 1, 3, 6);
    push(CMD_INVAL, 2, 3, 6);
    issue(REQ_WR, 3, 3);
    while (q.size() != 0) @(posedge clk);
    @(posedge clk); #1;
    req_valid = 1'b1; req_op = REQ_RD; req_src = 2'd1; req_blk = 3'd4;
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 other block stalled", req_ready, 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    push(CMD_NACK, 0, 3, 10);
    issue(REQ_RD, 0, 3);
    while (q.size() != 0) @(posedge clk);
    push(CMD_DATA, 3, 3, 6);
    drain();
    ref_dir[3] = {4'b1000, 1'b1};
    ack_dly = 1;
    xact(REQ_WR, 1, 3, 10);    // R10 owner still cache 3, nacked sender absent

    @(negedge clk);
    chk(q.size() == 0, "R11 queue drained", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule